// File: doc/BRIEF.md
# Byte-Bank Access Splitter

This block lets a CPU-side agent read or write 1, 2 or 4 bytes at any byte address of a 24-bit space. The memory behind it is 16 bits wide and is built from two 8-bit banks. The low bank sits on data lines 7:0 and answers even addresses. The high bank sits on lines 15:8 and is chosen by an active-low high-byte enable. Both banks see the same word address.

A request is taken in a single cycle on `req_start`. The splitter then issues one or more bus cycles, lowest address first. Each cycle is an even byte, an odd byte or an even word, and is encoded only by address bit 0 and the high-byte enable. On writes it steers each data byte onto the lane of the bank that holds it. On reads it collects the returned lanes into a right-justified result. Every bus cycle holds until the memory side acknowledges it. A one-cycle `done` pulse with the assembled value follows the last acknowledge.

Top module: `bytelane_splitter`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `busy`, `done` and `bus_strobe` are low.
- R2: Cycle encoding. An even-byte cycle drives `bus_a0`=0 and `bus_hbe_n`=1. An odd-byte cycle drives `bus_a0`=1 and `bus_hbe_n`=0. An even-word cycle drives `bus_a0`=0 and `bus_hbe_n`=0. The pair `bus_a0`=1 with `bus_hbe_n`=1 never appears while `bus_strobe` is high.
- R3: Cycles cover the requested bytes in ascending address order. A cycle at an odd address moves one byte. A cycle at an even address moves two bytes when at least two remain and one byte otherwise. `bus_waddr` is bits 23:1 of the cycle's first byte address. So a 2-byte access at an odd address is odd byte then even byte. A 4-byte access is word, word when aligned, and odd byte, word, even byte when the address is odd.
- R4: Size code `req_size`: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes.
- R5: Write steering. `bus_wdata[7:0]` carries the byte for the even address and `bus_wdata[15:8]` the byte for the odd address. In a word cycle the lower-addressed byte goes on 7:0. A lane whose bank is not enabled is driven with zero. Request byte 0 (bits 7:0 of `req_wdata`) belongs to the start address.
- R6: Read assembly. `rd_data` bits 7:0 hold the byte at the start address and higher bytes follow in ascending order. Bytes beyond the size are zero. Data on a lane whose bank is disabled is ignored. After a write, `rd_data` is zero.
- R7: `bus_strobe` stays high, with `bus_waddr`, `bus_a0`, `bus_hbe_n`, `bus_wdata` and `bus_write` unchanged, until a cycle with `bus_ack` high. A following cycle of the same access is presented in the very next clock.
- R8: `done` is high for exactly one clock, in the clock after the last cycle's acknowledge. `busy` is low while `done` is high, and a new request may be accepted in that clock.
- R9: A `req_start` that arrives while `busy` is high is ignored. It issues no extra bus cycle and does not alter the running access.
- R10: Addresses wrap. A byte that would fall past address 0xFFFFFF is taken from address 0x000000 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Begin an access; taken only while not busy |
| req_addr | input | 24 | Byte address of the first byte |
| req_size | input | 2 | Size code (R4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 32 | Assembled read result, right-justified |
| bus_strobe | output | 1 | A bus cycle is being presented |
| bus_write | output | 1 | Direction of the presented cycle |
| bus_waddr | output | 23 | Word address, byte address bits 23:1 |
| bus_a0 | output | 1 | Byte address bit 0; low enables the low bank |
| bus_hbe_n | output | 1 | Active-low high-bank enable |
| bus_wdata | output | 16 | Lane-steered write data |
| bus_rdata | input | 16 | Read data from both banks |
| bus_ack | input | 1 | Memory accepted the presented cycle |

## Verification
Some behaviour is checked by assertions on every clock. These cover the ban on the odd-address-with-high-bank-off pair, the bus outputs holding still while an acknowledge is pending, `done` following an acknowledge and lasting one clock, and the strobe staying low when the block is idle. Other behaviour only shows in the bench's scenarios against a two-bank memory model with varying wait states. That includes the order and kind of cycles chosen for each size and offset, the byte lanes used for write data, and the right-justified read values including wrap at the top of the address space. The same holds for the rejection of a start pulse issued mid-access.

// File: rtl/bls_pkg.sv
package bls_pkg;

    localparam int LANE_W    = 8;
    localparam int BUS_W     = 2 * LANE_W;
    localparam int MAX_BYTES = 4;
    localparam int DATA_W    = MAX_BYTES * LANE_W;
    localparam int IDX_W     = $clog2(MAX_BYTES);
    localparam int REM_W     = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        CYC_EVEN_BYTE = 2'd0,
        CYC_ODD_BYTE  = 2'd1,
        CYC_EVEN_WORD = 2'd2
    } cyc_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } split_state_e;

    typedef struct packed {
        logic             a0;
        logic             hbe_n;
        logic [REM_W-1:0] nbytes;
    } cyc_code_t;

    // Kind of the next cycle from the current byte address parity and bytes left
    function automatic cyc_kind_e pick_kind(input logic a0, input logic [REM_W-1:0] remain);
        if (a0)
            return CYC_ODD_BYTE;
        else if (remain >= REM_W'(2))
            return CYC_EVEN_WORD;
        else
            return CYC_EVEN_BYTE;
    endfunction

    function automatic cyc_code_t encode_kind(input cyc_kind_e k);
        cyc_code_t c;
        case (k)
            CYC_ODD_BYTE:  begin c.a0 = 1'b1; c.hbe_n = 1'b0; c.nbytes = REM_W'(1); end
            CYC_EVEN_WORD: begin c.a0 = 1'b0; c.hbe_n = 1'b0; c.nbytes = REM_W'(2); end
            default:       begin c.a0 = 1'b0; c.hbe_n = 1'b1; c.nbytes = REM_W'(1); end
        endcase
        return c;
    endfunction

    function automatic logic [REM_W-1:0] size_to_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return REM_W'(1);
            2'd1:    return REM_W'(2);
            default: return REM_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/bls_cycle_plan.sv
module bls_cycle_plan
    import bls_pkg::*;
(
    input  logic             cur_a0,
    input  logic [REM_W-1:0] remain,
    output cyc_kind_e        kind,
    output cyc_code_t        code
);
    always_comb begin
        kind = pick_kind(cur_a0, remain);
        code = encode_kind(kind);
    end
endmodule

// File: rtl/bls_wlane.sv
module bls_wlane
    import bls_pkg::*;
(
    input  cyc_kind_e          kind,
    input  logic [IDX_W-1:0]   idx,
    input  logic [DATA_W-1:0]  wdata,
    output logic [BUS_W-1:0]   lanes
);
    logic [DATA_W-1:0] shifted;
    logic [LANE_W-1:0] first_b;
    logic [LANE_W-1:0] second_b;

    always_comb begin
        shifted  = wdata >> {idx, 3'b000};
        first_b  = shifted[LANE_W-1:0];
        second_b = shifted[2*LANE_W-1:LANE_W];
        case (kind)
            CYC_ODD_BYTE:  lanes = {first_b, {LANE_W{1'b0}}};
            CYC_EVEN_WORD: lanes = {second_b, first_b};
            default:       lanes = {{LANE_W{1'b0}}, first_b};
        endcase
    end
endmodule

// File: rtl/bls_rmerge.sv
module bls_rmerge
    import bls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               capture,
    input  cyc_kind_e          kind,
    input  logic [IDX_W-1:0]   idx,
    input  logic [BUS_W-1:0]   rdata,
    output logic [DATA_W-1:0]  result
);
    logic [IDX_W-1:0] idx_next;
    assign idx_next = idx + IDX_W'(1);

    for (genvar j = 0; j < MAX_BYTES; j++) begin : g_slot
        localparam logic [IDX_W-1:0] SLOT = IDX_W'(j);
        logic [LANE_W-1:0] slot_q;

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_q <= '0;
            end else if (capture) begin
                case (kind)
                    CYC_ODD_BYTE:
                        if (idx == SLOT) slot_q <= rdata[BUS_W-1:LANE_W];
                    CYC_EVEN_WORD: begin
                        if (idx == SLOT)      slot_q <= rdata[LANE_W-1:0];
                        if (idx_next == SLOT) slot_q <= rdata[BUS_W-1:LANE_W];
                    end
                    default:
                        if (idx == SLOT) slot_q <= rdata[LANE_W-1:0];
                endcase
            end
        end

        assign result[j*LANE_W +: LANE_W] = slot_q;
    end
endmodule

// File: rtl/bytelane_splitter.sv
module bytelane_splitter
    import bls_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_start,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_write,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rd_data,
    output logic                bus_strobe,
    output logic                bus_write,
    output logic [ADDR_W-2:0]   bus_waddr,
    output logic                bus_a0,
    output logic                bus_hbe_n,
    output logic [BUS_W-1:0]    bus_wdata,
    input  logic [BUS_W-1:0]    bus_rdata,
    input  logic                bus_ack
);
    split_state_e       state_q;
    logic [ADDR_W-1:0]  cur_addr_q;
    logic [REM_W-1:0]   remain_q;
    logic [IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               write_q;
    logic               done_q;

    cyc_kind_e          kind;
    cyc_code_t          code;
    logic               accept;
    logic               step;
    logic               last_step;

    bls_cycle_plan u_plan (
        .cur_a0 (cur_addr_q[0]),
        .remain (remain_q),
        .kind   (kind),
        .code   (code)
    );

    bls_wlane u_wlane (
        .kind  (kind),
        .idx   (idx_q),
        .wdata (wdata_q),
        .lanes (bus_wdata)
    );

    bls_rmerge u_rmerge (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .capture (step && !write_q),
        .kind    (kind),
        .idx     (idx_q),
        .rdata   (bus_rdata),
        .result  (rd_data)
    );

    assign accept    = (state_q == ST_IDLE) && req_start;
    assign step      = (state_q == ST_BUS) && bus_ack;
    assign last_step = step && (remain_q == code.nbytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cur_addr_q <= '0;
            remain_q   <= '0;
            idx_q      <= '0;
            wdata_q    <= '0;
            write_q    <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                state_q    <= ST_BUS;
                cur_addr_q <= req_addr;
                remain_q   <= size_to_bytes(req_size);
                idx_q      <= '0;
                wdata_q    <= req_wdata;
                write_q    <= req_write;
            end else if (step) begin
                cur_addr_q <= cur_addr_q + ADDR_W'(code.nbytes);
                remain_q   <= remain_q - code.nbytes;
                idx_q      <= idx_q + IDX_W'(code.nbytes);
                if (last_step) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    assign busy       = (state_q == ST_BUS);
    assign done       = done_q;
    assign bus_strobe = (state_q == ST_BUS);
    assign bus_write  = write_q;
    assign bus_waddr  = cur_addr_q[ADDR_W-1:1];
    assign bus_a0     = code.a0;
    assign bus_hbe_n  = code.hbe_n;

    // R2
    illegal_pair_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> !(bus_a0 && bus_hbe_n));

    // R7
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_strobe && !bus_ack) |=> (bus_strobe && $stable(bus_waddr) && $stable(bus_a0)
            && $stable(bus_hbe_n) && $stable(bus_wdata) && $stable(bus_write)));

    // R8
    done_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(bus_strobe && bus_ack));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_strobe);

    // R3
    remain_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        bus_strobe |-> (remain_q != '0));

endmodule

// File: tb/bytelane_splitter_bench.sv
module bytelane_splitter_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic        req_start;
    logic [23:0] req_addr;
    logic [1:0]  req_size;
    logic        req_write;
    logic [31:0] req_wdata;
    logic        busy, done;
    logic [31:0] rd_data;
    logic        bus_strobe, bus_write, bus_a0, bus_hbe_n;
    logic [22:0] bus_waddr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        bus_ack;

    bytelane_splitter u_bytelane_splitter (
        .clk(clk), .rst(rst), .req_start(req_start), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data),
        .bus_strobe(bus_strobe), .bus_write(bus_write), .bus_waddr(bus_waddr),
        .bus_a0(bus_a0), .bus_hbe_n(bus_hbe_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack)
    );

    typedef struct packed {
        logic [22:0] waddr;
        logic        a0;
        logic        hbe_n;
        logic [15:0] wdata;
        logic        write;
    } cyc_t;

    cyc_t        exp_cyc[$];
    logic [31:0] exp_res[$];
    logic [7:0]  phys[int];
    logic [7:0]  refm[int];
    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int wait_cnt = 0;
    int wait_target = 0;

    function automatic logic [7:0] dflt(input int a);
        logic [31:0] v;
        v = a;
        return v[7:0] ^ v[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rd_phys(input int a);
        if (phys.exists(a)) return phys[a];
        return dflt(a);
    endfunction

    function automatic logic [7:0] rd_ref(input int a);
        if (refm.exists(a)) return refm[a];
        return dflt(a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory model and monitor: two 8-bit banks, variable wait states
    always @(negedge clk) begin
        if (rst) begin
            bus_ack = 1'b0;
            bus_rdata = 16'h0;
        end else begin
            if (done) begin
                done_cnt++;
                if (exp_res.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done", 64'(rd_data), 64'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_res.pop_front();
                    // R6: right-justified assembly; zero after writes
                    chk(rd_data == e, "R6", "result", 64'(rd_data), 64'(e));
                    // R8: not busy while done
                    chk(!busy, "R8", "busy during done", 64'(busy), 64'h0);
                end
            end
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_strobe) begin
                if (exp_cyc.size() == 0) begin
                    // R9: any extra cycle means a stray start was accepted
                    chk(1'b0, "R9", "unexpected bus cycle", 64'(bus_waddr), 64'h0);
                    bus_ack = 1'b1;
                end else begin
                    cyc_t e;
                    cyc_t a;
                    e = exp_cyc[0];
                    a.waddr = bus_waddr; a.a0 = bus_a0; a.hbe_n = bus_hbe_n;
                    a.write = bus_write;
                    a.wdata = e.write ? bus_wdata : 16'h0;
                    // R2 R3 R5 R7: kind, order, lanes, stability while waiting
                    chk(a == e, "R3", "bus cycle", 64'(a), 64'(e));
                    if (wait_cnt < wait_target) begin
                        wait_cnt++;
                    end else begin
                        int base;
                        void'(exp_cyc.pop_front());
                        base = int'({bus_waddr, 1'b0});
                        if (bus_write) begin
                            if (!bus_a0)    phys[base]     = bus_wdata[7:0];
                            if (!bus_hbe_n) phys[base + 1] = bus_wdata[15:8];
                            bus_rdata = 16'hEEEE;
                        end else begin
                            bus_rdata[7:0]  = !bus_a0    ? rd_phys(base)     : 8'hEE;
                            bus_rdata[15:8] = !bus_hbe_n ? rd_phys(base + 1) : 8'hEE;
                        end
                        bus_ack = 1'b1;
                        wait_cnt = 0;
                        wait_target = (wait_target + 1) % 3;
                    end
                end
            end
        end
    end

    task automatic access(input logic [23:0] a, input logic [1:0] sz, input bit wr,
                          input logic [31:0] wd, input bit glitch);
        int n;
        int rem;
        int k;
        int target;
        logic [23:0] pa;
        logic [31:0] res;
        n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        // R4 size decode, R3 cycle choice, R5 lanes, R10 wrap
        pa = a; rem = n; k = 0;
        while (rem > 0) begin
            cyc_t c;
            c.waddr = pa[23:1];
            c.write = wr;
            if (pa[0]) begin
                c.a0 = 1'b1; c.hbe_n = 1'b0;
                c.wdata = wr ? {wd[8*k +: 8], 8'h00} : 16'h0;
                pa = pa + 24'd1; rem -= 1; k += 1;
            end else if (rem >= 2) begin
                c.a0 = 1'b0; c.hbe_n = 1'b0;
                c.wdata = wr ? {wd[8*(k+1) +: 8], wd[8*k +: 8]} : 16'h0;
                pa = pa + 24'd2; rem -= 2; k += 2;
            end else begin
                c.a0 = 1'b0; c.hbe_n = 1'b1;
                c.wdata = wr ? {8'h00, wd[8*k +: 8]} : 16'h0;
                pa = pa + 24'd1; rem -= 1; k += 1;
            end
            exp_cyc.push_back(c);
        end
        res = 32'h0;
        for (int i = 0; i < n; i++) begin
            logic [23:0] ba;
            ba = a + 24'(i);
            if (wr) refm[int'(ba)] = wd[8*i +: 8];
            else    res[8*i +: 8] = rd_ref(int'(ba));
        end
        exp_res.push_back(res);
        while (busy) @(negedge clk);
        target = done_cnt + 1;
        req_start = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(negedge clk);
        req_start = 1'b0;
        if (glitch && exp_cyc.size() > 1) begin
            // R9: stray start with other fields while busy
            req_start = 1'b1; req_addr = ~a; req_size = 2'd0; req_write = ~wr; req_wdata = ~wd;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (done_cnt < target) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", 64'h0, 64'h1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst = 1'b1; req_start = 1'b0; req_addr = '0; req_size = '0;
        req_write = 1'b0; req_wdata = '0; bus_ack = 1'b0; bus_rdata = '0;
        repeat (3) @(negedge clk);
        // R1: quiet in reset
        chk(!busy && !done && !bus_strobe, "R1", "outputs in reset",
            64'({busy, done, bus_strobe}), 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bus_strobe, "R1", "outputs after reset",
            64'({busy, done, bus_strobe}), 64'h0);

        // R2 R3 R4 R5: every size code at every offset, writes then reads
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                access(24'h001000 + 24'(16 * s + o), 2'(s), 1'b1,
                       32'hA0B0C0D0 + 32'(s * 16 + o), 1'b0);
                access(24'h001000 + 24'(16 * s + o), 2'(s), 1'b0, 32'h0, 1'b0);
            end
        end

        // R10: wrap at the top of the address space
        access(24'hFFFFFF, 2'd2, 1'b1, 32'h11223344, 1'b0);
        access(24'hFFFFFF, 2'd2, 1'b0, 32'h0, 1'b0);
        access(24'h000000, 2'd1, 1'b0, 32'h0, 1'b0);
        access(24'hFFFFFE, 2'd3, 1'b0, 32'h0, 1'b0);

        // R9: stray starts while busy, R6 readback of overlapping writes
        lfsr = 16'hACE1;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            access(24'h002000 + 24'(lfsr[4:0]), lfsr[6:5], lfsr[7],
                   {lfsr, ~lfsr}, lfsr[8]);
        end
        access(24'h002003, 2'd2, 1'b0, 32'h0, 1'b1);
        access(24'h002001, 2'd1, 1'b0, 32'h0, 1'b1);

        repeat (4) @(negedge clk);
        chk(exp_cyc.size() == 0, "R3", "cycles left over", 64'(exp_cyc.size()), 64'h0);
        chk(exp_res.size() == 0, "R8", "results left over", 64'(exp_res.size()), 64'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule